// File: doc/BRIEF.md
# Staggered Channel Output Gating

This block produces the drive bits for a bank of constant-current LED channels. Each channel has a latched on/off bit. The block first qualifies that bit against three conditions that blank the whole bank: an active-low output enable, a thermal shutdown flag and an undervoltage lockout flag. It then delays each qualified bit by an amount that grows with the channel index. As a result, the channels switch one after another instead of all on the same edge, which keeps the supply in-rush current and ground bounce small.

Channel 0 passes through a single register. Each higher channel adds `STEP_CYC` clock cycles per index. The stagger applies in the same way when a channel turns on and when it turns off. The blanking conditions never alter the latched data, so every channel returns to its latched state once the condition clears. Each channel owns a private delay line, so a new change that enters while an earlier one is still rippling across the bank cannot disturb a channel that has already settled.

Top module: `chan_stagger_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `drive` is 0, whatever the other inputs are.
- R2: While `oe_n` is 1, the qualified value of every channel is 0, so each channel goes off once its own delay has elapsed, whatever `latch_on` holds.
- R3: While `oe_n`, `tsd` and `uvlo` are all 0, the qualified value of channel k equals `latch_on[k]`.
- R4: `drive[k]` after clock edge n equals the qualified value of channel k sampled at edge n − k·`STEP_CYC`. Channel 0 therefore updates on the same edge that samples its input, and each higher index adds `STEP_CYC` cycles.
- R5: The delay in R4 is identical for on-to-off and off-to-on changes.
- R6: While `tsd` is 1, every qualified value is 0. When `tsd` returns to 0, the channels resume the unchanged `latch_on` pattern with the delays of R4.
- R7: While `uvlo` is 1, every qualified value is 0. When `uvlo` returns to 0, the channels resume the unchanged `latch_on` pattern with the delays of R4.
- R8: Input changes that arrive on consecutive cycles, while earlier changes are still propagating, reach each channel exactly once and in order. No channel shows a value that its own delayed input did not have.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_on | input | NCH | Latched per-channel on/off bits (1 = on) |
| oe_n | input | 1 | Active-low output enable for the whole bank |
| tsd | input | 1 | Thermal shutdown flag, 1 blanks all channels |
| uvlo | input | 1 | Undervoltage lockout flag, 1 blanks all channels |
| drive | output | NCH | Staggered channel drive bits |

## Verification
Each result has a fixed due cycle. The qualified value sampled at edge n shows on `drive[k]` just after edge n + k·`STEP_CYC`, so channel 0 shows it after the sampling edge itself and channel 15 shows it 15·`STEP_CYC` edges later. The bench records the qualified vector it applied at every edge in a history array. After each edge it compares all channels against the history entry that lies k·`STEP_CYC` edges back, and it samples at the falling edge so that every register along the path has already updated. It checks every channel on every cycle, so an early or late transition, or a glitch on a settled channel, fails in the cycle where it occurs.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;
  // Register count from the gate output to the drive pin of one channel.
  function automatic int unsigned tap_depth(input int unsigned ch, input int unsigned step);
    return 1 + ch * step;
  endfunction

  // Qualified value of the whole bank: blank conditions clear every bit.
  function automatic logic blank_any(input logic oe_n, input logic tsd, input logic uvlo);
    return oe_n | tsd | uvlo;
  endfunction
endpackage

// File: rtl/stg_gate.sv
`timescale 1ns/1ps
module stg_gate #(
  parameter int unsigned NCH = 16
) (
  input  logic [NCH-1:0] latch_on,
  input  logic           oe_n,
  input  logic           tsd,
  input  logic           uvlo,
  output logic [NCH-1:0] gated
);
  import stg_pkg::*;

  logic kill;

  always_comb begin
    kill  = blank_any(oe_n, tsd, uvlo);
    gated = kill ? '0 : latch_on;
  end
endmodule

// File: rtl/stg_delay_line.sv
`timescale 1ns/1ps
module stg_delay_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic pre
);
  logic [DEPTH-1:0] sr;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= din;
      end
      assign pre = din;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], din};
      end
      assign pre = sr[DEPTH-2];
    end
  endgenerate

  assign dout = sr[DEPTH-1];
endmodule

// File: rtl/chan_stagger_gate.sv
`timescale 1ns/1ps
module chan_stagger_gate #(
  parameter int unsigned NCH      = 16,
  parameter int unsigned STEP_CYC = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] latch_on,
  input  logic           oe_n,
  input  logic           tsd,
  input  logic           uvlo,
  output logic [NCH-1:0] drive
);
  import stg_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] gated;    // qualified bits before any delay
  logic [NCH-1:0] pre_tap;  // value one register ahead of each drive bit

  stg_gate #(.NCH(NCH)) u_gate (
    .latch_on (latch_on),
    .oe_n     (oe_n),
    .tsd      (tsd),
    .uvlo     (uvlo),
    .gated    (gated)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int unsigned DEPTH = tap_depth(ch, STEP_CYC);
      stg_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gated[ch]),
        .dout  (drive[ch]),
        .pre   (pre_tap[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/chan_stagger_gate_chk.sv
`timescale 1ns/1ps
module chan_stagger_gate_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] latch_on,
  input logic           oe_n,
  input logic           tsd,
  input logic           uvlo,
  input logic [NCH-1:0] drive,
  input logic [NCH-1:0] pre_tap
);
  // R1: drive cleared while reset is held
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> drive == '0);

  // R2: output enable high blanks channel 0 on the next edge
  a_r2_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !drive[0]);

  // R3: channel 0 follows its latch bit when nothing blanks it
  a_r3_ch0_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !tsd && !uvlo) |=> drive[0] == $past(latch_on[0]));

  // R6: thermal shutdown blanks channel 0
  a_r6_tsd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    tsd |=> !drive[0]);

  // R7: lockout blanks channel 0
  a_r7_uvlo_blank: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !drive[0]);

  // R8: each drive bit only ever takes the value its own chain held one cycle earlier
  generate
    for (genvar k = 0; k < NCH; k++) begin : g_tap
      a_r8_tap_shift: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> drive[k] == $past(pre_tap[k]));
    end
  endgenerate
endmodule

bind chan_stagger_gate chan_stagger_gate_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .latch_on (latch_on),
  .oe_n     (oe_n),
  .tsd      (tsd),
  .uvlo     (uvlo),
  .drive    (drive),
  .pre_tap  (pre_tap)
);

// File: tb/sim_chan_stagger_gate.sv
`timescale 1ns/1ps
module sim_chan_stagger_gate;
  localparam int NCH  = 16;
  localparam int STEP = 2;
  localparam int HMAX = 2048;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] latch_on;
  logic           oe_n, tsd, uvlo;
  logic [NCH-1:0] drive;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [NCH-1:0] hist [0:HMAX-1];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  chan_stagger_gate #(.NCH(NCH), .STEP_CYC(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .latch_on(latch_on), .oe_n(oe_n),
    .tsd(tsd), .uvlo(uvlo), .drive(drive)
  );

  function automatic void summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endfunction

  // One clock: record the qualified vector applied at this edge, then
  // compare every channel with the entry k*STEP edges back (R4, R5).
  task automatic tick(input string tag);
    @(posedge clk);
    cyc++;
    hist[cyc] = (oe_n | tsd | uvlo) ? '0 : latch_on;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) begin
      int idx;
      logic expv;
      idx  = cyc - k * STEP;
      expv = (idx >= 0) ? hist[idx][k] : 1'b0;
      checks++;
      if (drive[k] !== expv) begin
        errors++;
        $display("FAIL %s cycle %0d ch %0d: drive=%b expected=%b", tag, cyc, k, drive[k], expv);
      end
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; latch_on = '1; oe_n = 1'b0; tsd = 1'b0; uvlo = 1'b0;
    for (int i = 0; i < HMAX; i++) hist[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: drive stays clear under reset even with all channels requested
    checks++;
    if (drive !== '0) begin
      errors++;
      $display("FAIL R1 reset: drive=%h expected=0000", drive);
    end
    latch_on = '0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;

    latch_on = 16'hFFFF; run(40, "R3 all on");
    latch_on = 16'h0000; run(40, "R5 all off");
    for (int c = 0; c < NCH; c++) begin
      latch_on = 16'(1) << c; run(3, "R4 walk");
    end
    latch_on = 16'h0000; run(35, "R4 settle");
    latch_on = 16'hA5A5; run(35, "R3 pattern");
    oe_n = 1'b1; run(40, "R2 oe high");
    oe_n = 1'b0; run(35, "R2 oe low");
    tsd  = 1'b1; run(40, "R6 tsd");
    tsd  = 1'b0; run(35, "R6 resume");
    latch_on = 16'h3C5A;
    uvlo = 1'b1; run(40, "R7 uvlo");
    uvlo = 1'b0; run(35, "R7 resume");
    for (int i = 0; i < 200; i++) begin
      if (i % 2 == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        latch_on = lfsr;
        oe_n = (lfsr[3:0] == 4'h0);
      end
      tick("R8 ripple");
    end
    oe_n = 1'b0; run(35, "R8 drain");
    summary();
    $finish;
  end
endmodule